// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a shared RAM that several hardware contexts use. It watches the request stream and keeps a small table of address reservations for load-linked / store-conditional sequences. It decides, for each store, whether the write may reach the RAM. For each store-conditional it also reports a pass or fail result to the requester.

A reservation covers one aligned 16-byte granule and belongs to the context that made it. Every store, whether plain or conditional, is compared against the whole table and wipes any reservation on its granule. A plain store always proceeds. A conditional store proceeds only while its own context still holds a reservation on that granule. The write-enable and result outputs are registered. They appear in the cycle after the request and drive the RAM's write strobe and the requester's return value.

Top module: `llsc_monitor`

## Requirements
- R1: Reservations cover 16-byte granules. Two addresses that differ only in bits [3:0] match each other. Addresses that differ in bit 4 or above do not match.
- R2: The op codes on req_op_i are 0 = plain load, 1 = load-linked, 2 = plain store and 3 = store-conditional. A load-linked (1) records a reservation for its context. A later store-conditional (3) from the same context to the same granule then succeeds: wr_en_o=1, sc_valid_o=1 and sc_result_o=1.
- R3: A store-conditional whose context holds no reservation on the granule fails, even if another context holds one. It gives wr_en_o=0, sc_valid_o=1 and sc_result_o=0.
- R4: A plain store (2) always gives wr_en_o=1 and sc_valid_o=0. It clears every matching reservation, whichever context owns it.
- R5: A store-conditional presented while the table is empty fails with result 0 and no write.
- R6: A successful store-conditional clears its own reservation, so a repeat store-conditional to that granule fails.
- R7: A failing store-conditional still clears the matching reservations of other contexts.
- R8: Plain loads (0) and load-linked requests (1) raise neither wr_en_o nor sc_valid_o. They clear no reservation of any context.
- R9: A new load-linked from a context replaces that context's earlier reservation, so the old granule is no longer reserved for it.
- R10: The table holds DEPTH entries (default 4). A load-linked from a new context into a full table evicts the oldest reservation and keeps the others.
- R11: Outputs are registered. They reflect the request of the previous cycle only, and are all 0 after a cycle with req_valid_i low.
- R12: The active-low asynchronous reset drives all outputs to 0 and invalidates every reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_op_i | input | 2 | Operation: 0 load, 1 load-linked, 2 store, 3 store-conditional |
| req_addr_i | input | ADDR_W | Physical byte address |
| req_ctx_i | input | CTX_W | Issuing context ID |
| wr_en_o | output | 1 | Store may write the RAM (one cycle after the request) |
| sc_valid_o | output | 1 | Store-conditional result is valid |
| sc_result_o | output | 1 | Store-conditional result: 1 success, 0 fail |

## Verification
The assertions assume at most one request per cycle. They also assume that req_op_i and req_ctx_i hold known values whenever req_valid_i is high, since the checks tie each output to the operation seen one edge earlier. The stimulus drives each request for exactly one clock period, changing inputs only on the falling edge. It keeps the valid strobe low between scenarios, and a reset starts every scenario so that table contents stay known. Eviction is reached by using more distinct contexts than the table has entries. That is why the context field is wider than the depth needs.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LINK  = 2'd1,
    OP_STORE = 2'd2,
    OP_COND  = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28,
  parameter int CTX_W = 3
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][TAG_W-1:0] tag_i,
  input  logic [DEPTH-1:0][CTX_W-1:0] ctx_i,
  input  logic [TAG_W-1:0]            req_tag_i,
  input  logic [CTX_W-1:0]            req_ctx_i,
  output logic [DEPTH-1:0]            addr_hit_o,
  output logic [DEPTH-1:0]            ctx_hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign addr_hit_o[g] = valid_i[g] && (tag_i[g] == req_tag_i);
    assign ctx_hit_o[g]  = valid_i[g] && (ctx_i[g] == req_ctx_i);
  end
endmodule

// File: rtl/llsc_decide.sv
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             req_valid_i,
  input  llsc_op_e         req_op_i,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] addr_hit_i,
  input  logic [DEPTH-1:0] ctx_hit_i,
  output logic [DEPTH-1:0] keep_o,
  output logic             ins_o,
  output logic             wr_en_o,
  output logic             sc_valid_o,
  output logic             sc_result_o
);
  logic own_hit;
  assign own_hit = |(addr_hit_i & ctx_hit_i);

  always_comb begin
    keep_o      = valid_i;
    ins_o       = 1'b0;
    wr_en_o     = 1'b0;
    sc_valid_o  = 1'b0;
    sc_result_o = 1'b0;
    if (req_valid_i) begin
      unique case (req_op_i)
        OP_LINK: begin
          keep_o = valid_i & ~ctx_hit_i;
          ins_o  = 1'b1;
        end
        OP_STORE: begin
          keep_o  = valid_i & ~addr_hit_i;
          wr_en_o = 1'b1;
        end
        OP_COND: begin
          // every store wipes matching granules, pass or fail
          keep_o      = valid_i & ~addr_hit_i;
          sc_valid_o  = 1'b1;
          sc_result_o = own_hit;
          wr_en_o     = own_hit;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/llsc_table.sv
module llsc_table #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 28,
  parameter int CTX_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ins_i,
  input  logic [TAG_W-1:0]            ins_tag_i,
  input  logic [CTX_W-1:0]            ins_ctx_i,
  input  logic [DEPTH-1:0]            keep_i,
  output logic [DEPTH-1:0]            valid_o,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_o,
  output logic [DEPTH-1:0][CTX_W-1:0] ctx_o
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = SEL_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DEPTH-1:0]            valid_q, valid_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [DEPTH-1:0][CTX_W-1:0] ctx_q, ctx_d;

  // slot 0 is newest; survivors are packed in age order, the tail drops out
  always_comb begin
    logic [CNT_W-1:0] idx;
    valid_d = '0;
    tag_d   = tag_q;
    ctx_d   = ctx_q;
    idx     = '0;
    if (ins_i) begin
      valid_d[0] = 1'b1;
      tag_d[0]   = ins_tag_i;
      ctx_d[0]   = ins_ctx_i;
      idx        = CNT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep_i[i] && (idx < DEPTH_C)) begin
        valid_d[idx[SEL_W-1:0]] = 1'b1;
        tag_d[idx[SEL_W-1:0]]   = tag_q[i];
        ctx_d[idx[SEL_W-1:0]]   = ctx_q[i];
        idx = idx + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      ctx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      ctx_q   <= ctx_d;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign ctx_o   = ctx_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 3,
  parameter int DEPTH     = 4,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  output logic              wr_en_o,
  output logic              sc_valid_o,
  output logic              sc_result_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  llsc_op_e                    op;
  logic [TAG_W-1:0]            req_tag;
  logic [DEPTH-1:0]            tbl_valid;
  logic [DEPTH-1:0][TAG_W-1:0] tbl_tag;
  logic [DEPTH-1:0][CTX_W-1:0] tbl_ctx;
  logic [DEPTH-1:0]            addr_hit, ctx_hit, keep;
  logic                        ins, wr_d, scv_d, scr_d;

  assign op      = llsc_op_e'(req_op_i);
  assign req_tag = req_addr_i[ADDR_W-1:GRAN_BITS];

  llsc_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
    .valid_i    (tbl_valid),
    .tag_i      (tbl_tag),
    .ctx_i      (tbl_ctx),
    .req_tag_i  (req_tag),
    .req_ctx_i  (req_ctx_i),
    .addr_hit_o (addr_hit),
    .ctx_hit_o  (ctx_hit)
  );

  llsc_decide #(.DEPTH(DEPTH)) u_decide (
    .req_valid_i (req_valid_i),
    .req_op_i    (op),
    .valid_i     (tbl_valid),
    .addr_hit_i  (addr_hit),
    .ctx_hit_i   (ctx_hit),
    .keep_o      (keep),
    .ins_o       (ins),
    .wr_en_o     (wr_d),
    .sc_valid_o  (scv_d),
    .sc_result_o (scr_d)
  );

  llsc_table #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_i     (ins),
    .ins_tag_i (req_tag),
    .ins_ctx_i (req_ctx_i),
    .keep_i    (keep),
    .valid_o   (tbl_valid),
    .tag_o     (tbl_tag),
    .ctx_o     (tbl_ctx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o     <= 1'b0;
      sc_valid_o  <= 1'b0;
      sc_result_o <= 1'b0;
    end else begin
      wr_en_o     <= wr_d;
      sc_valid_o  <= scv_d;
      sc_result_o <= scr_d;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int DEPTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_op_i,
  input logic             wr_en_o,
  input logic             sc_valid_o,
  input logic             sc_result_o,
  input logic [DEPTH-1:0] valid_i
);
  // R4
  store_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd2 |=> wr_en_o && !sc_valid_o);
  // R8
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_op_i[1] |=> !wr_en_o && !sc_valid_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !wr_en_o && !sc_valid_o);
  // R11
  sc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd3 |=> sc_valid_o);
  // R3
  sc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_valid_o |-> wr_en_o == sc_result_o);
  // R2
  result_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_result_o |-> sc_valid_o);
  // R9
  link_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd1 |=> valid_i != '0);
  // R5
  empty_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd3 && valid_i == '0 |=> !sc_result_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .wr_en_o     (wr_en_o),
  .sc_valid_o  (sc_valid_o),
  .sc_result_o (sc_result_o),
  .valid_i     (tbl_valid)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int ADDR_W = 32;
  localparam int CTX_W  = 3;

  localparam logic [1:0] LD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;
  localparam logic [2:0] NONE = 3'b000, WRITE = 3'b100, PASS = 3'b111, FAILD = 3'b010;
  localparam logic [ADDR_W-1:0] A = 32'h0000_1000, B = 32'h0000_2040;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CTX_W-1:0]  req_ctx = '0;
  logic              wr_en, sc_valid, sc_result;
  int                n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_ctx_i   (req_ctx),
    .wr_en_o     (wr_en),
    .sc_valid_o  (sc_valid),
    .sc_result_o (sc_result)
  );

  task automatic check(string rq, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s {wr,scv,scr} act=%b exp=%b", rq, act, exp);
    end
  endtask

  // one-cycle request driven on the falling edge, outputs sampled one period later
  task automatic req(logic [1:0] op, logic [ADDR_W-1:0] addr, logic [CTX_W-1:0] ctx,
                     string rq, logic [2:0] exp);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_ctx = ctx;
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, {wr_en, sc_valid, sc_result}, exp);
  endtask

  task automatic idle(string rq);
    @(negedge clk);
    check(rq, {wr_en, sc_valid, sc_result}, NONE);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R12 outputs after reset", {wr_en, sc_valid, sc_result}, NONE);
    req(LL, A, 3'd0, "R8 link quiet", NONE);
    do_reset();
    req(SC, A, 3'd0, "R12 reservation gone after reset", FAILD);
  endtask

  task automatic t_empty();
    do_reset();
    req(SC, A, 3'd1, "R5 sc on empty table", FAILD);
    req(ST, A, 3'd1, "R4 store on empty table", WRITE);
  endtask

  task automatic t_basic();
    do_reset();
    req(LL, A, 3'd0, "R8 link no outputs", NONE);
    req(SC, A + 32'h4, 3'd0, "R2 sc own reservation", PASS);
    req(SC, A, 3'd0, "R6 repeat sc fails", FAILD);
  endtask

  task automatic t_gran();
    do_reset();
    req(LL, A, 3'd0, "R8 link", NONE);
    req(SC, A + 32'h10, 3'd0, "R1 next granule misses", FAILD);
    req(SC, A + 32'hF, 3'd0, "R1 same granule hits", PASS);
  endtask

  task automatic t_other();
    do_reset();
    req(LL, A, 3'd0, "R8 link", NONE);
    req(SC, A, 3'd1, "R3 foreign sc fails", FAILD);
    req(SC, A, 3'd0, "R7 failed sc cleared owner", FAILD);
  endtask

  task automatic t_store();
    do_reset();
    req(LL, A, 3'd0, "R8 link c0", NONE);
    req(LL, A, 3'd1, "R8 link c1", NONE);
    req(ST, A + 32'h8, 3'd2, "R4 plain store writes", WRITE);
    req(SC, A, 3'd0, "R4 store cleared c0", FAILD);
    req(SC, A, 3'd1, "R4 store cleared c1", FAILD);
  endtask

  task automatic t_load();
    do_reset();
    req(LL, A, 3'd0, "R8 link c0", NONE);
    req(LD, A, 3'd1, "R8 load quiet", NONE);
    req(LL, A, 3'd1, "R8 other link quiet", NONE);
    req(SC, A, 3'd0, "R8 reservation survived", PASS);
  endtask

  task automatic t_replace();
    do_reset();
    req(LL, A, 3'd0, "R8 link A", NONE);
    req(LL, B, 3'd0, "R8 link B", NONE);
    req(SC, A, 3'd0, "R9 old granule dropped", FAILD);
    req(SC, B, 3'd0, "R9 new granule held", PASS);
  endtask

  task automatic t_evict();
    do_reset();
    for (int i = 0; i < 5; i++)
      req(LL, A + 32'(i * 16), CTX_W'(i), "R8 link fill", NONE);
    req(SC, A, 3'd0, "R10 oldest evicted", FAILD);
    req(SC, A + 32'h10, 3'd1, "R10 next oldest kept", PASS);
    req(SC, A + 32'h40, 3'd4, "R10 newest kept", PASS);
  endtask

  task automatic t_timing();
    do_reset();
    req(LL, A, 3'd2, "R11 link", NONE);
    idle("R11 idle after link");
    req(SC, A, 3'd2, "R11 sc result next cycle", PASS);
    idle("R11 outputs drop after sc");
    req(ST, B, 3'd3, "R11 store", WRITE);
    idle("R11 outputs drop after store");
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_empty();
    t_basic();
    t_gran();
    t_other();
    t_store();
    t_load();
    t_replace();
    t_evict();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule